// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog timer with a small register window on a fast bus clock and its counting logic on a separate slow clock. Software sets a load value, optionally turns on a power-of-two prescaler, and then arms the counter. Arming and disarming both need a two-word key written to one register. Once armed, the counter climbs from the load value. Software keeps it away from the top by writing a new value to the kick register, which reloads the counter. If the counter wraps past all-ones, the block drives a reset pulse for a fixed number of slow cycles.

Every write that lands in the slow domain is posted. The bus side keeps the written word and hands it across with a toggle request and acknowledge. While that transfer is in flight, the register's own bit in a status word stays high. A new write to that register during this time is discarded. The bus port is a plain write strobe with combinational read data. There is no back-pressure, so software is expected to poll the status word before rewriting a register. The count is brought back to the bus side through a two-stage synchronizer and reads exactly whenever it is not changing.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the counter reads 0 and is stopped, the status word reads 0, control and load read 0, and the reset output is low.
- R2: Word address 0 reads the REVISION parameter in bits 7:0 and 0 elsewhere; writes to it change nothing.
- R3: The status word (address 6) has bit 0 for control, bit 2 for load, bit 3 for kick and bit 4 for key. A bit reads 1 from the cycle after an accepted write to that register until the slow domain has taken the value, then returns to 0. A write to a register whose bit is 1 is discarded.
- R4: Writing 0xBBBB and then 0x4444 to the key register (address 5) starts the counter.
- R5: Writing 0xAAAA and then 0x5555 to the key register stops the counter.
- R6: Any other key word leaves the run state unchanged and returns the key tracker to idle. This covers a lone second word, a wrong second word, and a repeated first word. For example, 0xBBBB, 0xBBBB, 0x4444 does not start the counter.
- R7: A kick write (address 4) whose value differs from the previous kick value copies the load register (address 3) into the counter. The previous kick value is 0 after reset. A kick equal to the previous value has no effect.
- R8: While running with the prescaler off, the counter rises by exactly one per slow clock cycle. While stopped it holds.
- R9: With control bit 5 set, the counter rises once every 2^r slow cycles, where r is control bits 4:2.
- R10: When the running counter steps past all-ones, it wraps to 0 and keeps running, and the reset output is high for exactly RST_CYCLES slow cycles.
- R11: Control (address 1) reads back bits 5:2 of the last accepted write with bits 1:0 as 0. Load reads the last accepted value. Address 2 reads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register access clock |
| slow_clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| addr | input | 3 | Word address |
| wdata | input | CNT_W | Write data (CNT_W at least 16) |
| rdata | output | CNT_W | Read data for addr, combinational |
| wdt_rst | output | 1 | Reset request pulse, slow domain |

## Verification
The hardest thing to reach from the ports is a wrap past all-ones. At the slow rate, counting up from zero would take far too long. The stimulus loads a value sixteen below the top, kicks with a fresh value while the counter is stopped, and only then arms it. The bench then confirms one pulse of the exact width and that the count has wrapped while still running. Exact rate checks are possible from the bus side only because each pair of count reads sits at the same phase relative to the slow clock.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam logic [2:0] A_REV   = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_COUNT = 3'd2;
  localparam logic [2:0] A_LOAD  = 3'd3;
  localparam logic [2:0] A_KICK  = 3'd4;
  localparam logic [2:0] A_KEY   = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;

  localparam int KEY_W   = 16;
  localparam int CFG_W   = 4;  // stored control bits 5:2
  localparam int RATIO_W = 3;

  localparam logic [KEY_W-1:0] GO_FIRST    = 16'hBBBB;
  localparam logic [KEY_W-1:0] GO_SECOND   = 16'h4444;
  localparam logic [KEY_W-1:0] HALT_FIRST  = 16'hAAAA;
  localparam logic [KEY_W-1:0] HALT_SECOND = 16'h5555;

  typedef enum logic [1:0] {KEY_IDLE, KEY_GO, KEY_HALT} key_st_e;
endpackage

// File: rtl/wdt_xfer.sv
`timescale 1ns/1ps
// Posted write channel: bus-side holding register plus toggle handshake.
module wdt_xfer #(
  parameter int W = 8
) (
  input  logic         bus_clk,
  input  logic         slow_clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow_q,
  output logic         pend,
  output logic         upd,
  output logic [W-1:0] sdata
);
  logic req_t, ack_b1, ack_b2;
  logic req_s1, req_s2, req_s3;

  assign pend  = req_t ^ ack_b2;
  assign upd   = req_s2 ^ req_s3;
  assign sdata = shadow_q;  // held stable while the request is open

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_t    <= 1'b0;
      ack_b1   <= 1'b0;
      ack_b2   <= 1'b0;
      shadow_q <= '0;
    end else begin
      ack_b1 <= req_s3;
      ack_b2 <= ack_b1;
      if (wr && !pend) begin
        shadow_q <= wdata;
        req_t    <= ~req_t;
      end
    end
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      req_s3 <= 1'b0;
    end else begin
      req_s1 <= req_t;
      req_s2 <= req_s1;
      req_s3 <= req_s2;
    end
  end

  // R3
  drop_when_busy_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr && pend) |=> $stable(shadow_q));
endmodule

// File: rtl/wdt_presc.sv
`timescale 1ns/1ps
// Power-of-two tick divider on the slow clock.
module wdt_presc #(
  parameter int RATIO_W = 3
) (
  input  logic               slow_clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               restart,
  output logic               tick
);
  localparam int DIV_W = 1 << RATIO_W;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = (DIV_W'(1) << ratio) - DIV_W'(1);
  assign tick  = run && (!en || div_q == limit);

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n)                 div_q <= '0;
    else if (!run || restart)   div_q <= '0;
    else if (tick)              div_q <= '0;
    else                        div_q <= div_q + DIV_W'(1);
  end

  // R9
  tick_spacing_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (tick && en && ratio != '0 && !restart) |=> !tick);
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
// Slow-domain state: configuration, key tracker, counter and reset pulse.
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             cfg_upd,
  input  logic [CFG_W-1:0] cfg_d,
  input  logic             load_upd,
  input  logic [CNT_W-1:0] load_d,
  input  logic             kick_upd,
  input  logic [CNT_W-1:0] kick_d,
  input  logic             key_upd,
  input  logic [KEY_W-1:0] key_d,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wdt_rst
);
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] load_q, last_kick;
  logic             run_q;
  key_st_e          key_st;
  logic [RST_W-1:0] rst_cnt;
  logic             tick, reload, wrap;

  assign reload  = kick_upd && (kick_d != last_kick);
  assign wrap    = tick && (&cnt_q) && !reload;
  assign wdt_rst = (rst_cnt != '0);

  wdt_presc #(.RATIO_W(RATIO_W)) u_presc (
    .slow_clk (slow_clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .en       (cfg_q[CFG_W-1]),
    .ratio    (cfg_q[RATIO_W-1:0]),
    .restart  (cfg_upd),
    .tick     (tick)
  );

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      load_q    <= '0;
      last_kick <= '0;
    end else begin
      if (cfg_upd)  cfg_q     <= cfg_d;
      if (load_upd) load_q    <= load_d;
      if (kick_upd) last_kick <= kick_d;
    end
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (reload) cnt_q <= load_q;
    else if (tick)   cnt_q <= cnt_q + CNT_W'(1);
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n)              rst_cnt <= '0;
    else if (wrap)           rst_cnt <= RST_W'(RST_CYCLES);
    else if (rst_cnt != '0)  rst_cnt <= rst_cnt - RST_W'(1);
  end

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      key_st <= KEY_IDLE;
      run_q  <= 1'b0;
    end else if (key_upd) begin
      unique case (key_st)
        KEY_IDLE: begin
          if (key_d == GO_FIRST)        key_st <= KEY_GO;
          else if (key_d == HALT_FIRST) key_st <= KEY_HALT;
          else                          key_st <= KEY_IDLE;
        end
        KEY_GO: begin
          if (key_d == GO_SECOND) run_q <= 1'b1;
          key_st <= KEY_IDLE;
        end
        KEY_HALT: begin
          if (key_d == HALT_SECOND) run_q <= 1'b0;
          key_st <= KEY_IDLE;
        end
        default: key_st <= KEY_IDLE;
      endcase
    end
  end

  // R8
  hold_when_stopped_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    (!run_q && !kick_upd) |=> $stable(cnt_q));
  // R6
  run_only_on_key_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    !key_upd |=> $stable(run_q));
  // R10
  rst_after_wrap_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> (cnt_q == '0 && $past(run_q)));
endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int         CNT_W      = 32,
  parameter logic [7:0] REVISION   = 8'h31,
  parameter int         RST_CYCLES = 4
) (
  input  logic             bus_clk,
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             wdt_rst
);
  logic [CFG_W-1:0] cfg_sh, cfg_sd;
  logic [CNT_W-1:0] load_sh, load_sd, kick_sh, kick_sd;
  logic [KEY_W-1:0] key_sh, key_sd;
  logic p_cfg, p_load, p_kick, p_key;
  logic u_cfg, u_load, u_kick, u_key;
  logic [CNT_W-1:0] cnt_slow, cnt_b1, cnt_b2;

  wdt_xfer #(.W(CFG_W)) u_x_cfg (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .wr(wr_en && addr == A_CTRL), .wdata(wdata[5:2]),
    .shadow_q(cfg_sh), .pend(p_cfg), .upd(u_cfg), .sdata(cfg_sd));

  wdt_xfer #(.W(CNT_W)) u_x_load (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .wr(wr_en && addr == A_LOAD), .wdata(wdata),
    .shadow_q(load_sh), .pend(p_load), .upd(u_load), .sdata(load_sd));

  wdt_xfer #(.W(CNT_W)) u_x_kick (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .wr(wr_en && addr == A_KICK), .wdata(wdata),
    .shadow_q(kick_sh), .pend(p_kick), .upd(u_kick), .sdata(kick_sd));

  wdt_xfer #(.W(KEY_W)) u_x_key (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .wr(wr_en && addr == A_KEY), .wdata(wdata[KEY_W-1:0]),
    .shadow_q(key_sh), .pend(p_key), .upd(u_key), .sdata(key_sd));

  wdt_core #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) u_core (
    .slow_clk(slow_clk), .rst_n(rst_n),
    .cfg_upd(u_cfg), .cfg_d(cfg_sd),
    .load_upd(u_load), .load_d(load_sd),
    .kick_upd(u_kick), .kick_d(kick_sd),
    .key_upd(u_key), .key_d(key_sd),
    .cnt_q(cnt_slow), .wdt_rst(wdt_rst));

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_b1 <= '0;
      cnt_b2 <= '0;
    end else begin
      cnt_b1 <= cnt_slow;
      cnt_b2 <= cnt_b1;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_REV:   rdata = CNT_W'(REVISION);
      A_CTRL:  rdata = CNT_W'({cfg_sh, 2'b00});
      A_COUNT: rdata = cnt_b2;
      A_LOAD:  rdata = load_sh;
      A_STAT:  rdata = CNT_W'({p_key, p_kick, p_load, 1'b0, p_cfg});
      default: rdata = '0;
    endcase
  end

  // R3
  pend_rises_on_write_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (wr_en && addr == A_LOAD && !p_load) |=> p_load);
endmodule

// File: tb/wdt_keyed_tb.sv
`timescale 1ns/1ps
module wdt_keyed_tb;
  import wdt_pkg::*;
  localparam int         CW   = 32;
  localparam int         RSTC = 4;
  localparam logic [7:0] REV  = 8'h31;

  logic bus_clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0]    addr  = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          wdt_rst;

  int vecs = 0, errs = 0, hi_len = 0, pulses = 0;
  bit pulse_ok = 1'b0, done = 1'b0;
  // behavioural reference state
  bit            m_run = 1'b0;
  int            m_key = 0;
  logic [CW-1:0] m_last_kick = '0;
  logic [CW-1:0] m_load = '0;

  always #5 bus_clk = ~bus_clk;
  initial begin #2; forever #40 slow_clk = ~slow_clk; end

  wdt_keyed #(.CNT_W(CW), .REVISION(REV), .RST_CYCLES(RSTC)) u_dut (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst));

  task automatic chk(input string tag, input logic [CW-1:0] got, input logic [CW-1:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] v);
    @(negedge bus_clk); addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge bus_clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge bus_clk); wr_en = 1'b0;
  endtask

  task automatic drain();
    logic [CW-1:0] s;
    s = '1;
    for (int i = 0; i < 400 && s != '0; i++) rd(A_STAT, s);
    chk("R3 pending clears", s, '0);
  endtask

  task automatic wrw(input logic [2:0] a, input logic [CW-1:0] d);
    wr(a, d); drain();
  endtask

  task automatic key(input logic [15:0] k);
    wrw(A_KEY, CW'(k));
    case (m_key)
      0: m_key = (k == 16'hBBBB) ? 1 : (k == 16'hAAAA) ? 2 : 0;
      1: begin if (k == 16'h4444) m_run = 1'b1; m_key = 0; end
      default: begin if (k == 16'h5555) m_run = 1'b0; m_key = 0; end
    endcase
  endtask

  task automatic kick(input logic [CW-1:0] v);
    wrw(A_KICK, v);
    m_last_kick = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge slow_clk);
    repeat (4) @(negedge bus_clk);
  endtask

  task automatic rate(input int n, output logic [CW-1:0] d);
    logic [CW-1:0] c1, c2;
    settle(2); rd(A_COUNT, c1);
    settle(n); rd(A_COUNT, c2);
    d = c2 - c1;
  endtask

  task automatic check_run(input string tag);
    logic [CW-1:0] d;
    rate(16, d);
    chk(tag, CW'(d != '0), CW'(m_run));
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  // pulse width against RST_CYCLES, and no pulse outside the wrap test
  always @(posedge slow_clk) begin
    if (rst_n) begin
      if (wdt_rst) hi_len++;
      else if (hi_len != 0) begin
        pulses++;
        chk("R10 pulse width", CW'(hi_len), CW'(RSTC));
        hi_len = 0;
      end
    end
  end

  always @(negedge bus_clk) begin
    if (rst_n && !pulse_ok) chk("R1 reset output idle", CW'(wdt_rst), '0);
  end

  initial begin
    #1_500_000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [CW-1:0] v, ca, cb, d;
    repeat (5) @(negedge bus_clk);
    rst_n = 1'b1;

    // R1, R2
    rd(A_REV, v);   chk("R2 revision", v, CW'(REV));
    rd(A_STAT, v);  chk("R1 status", v, '0);
    rd(A_COUNT, v); chk("R1 count", v, '0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, '0);
    rd(A_LOAD, v);  chk("R1 load", v, '0);
    wr(A_REV, '1); settle(4);
    rd(A_REV, v);   chk("R2 revision write ignored", v, CW'(REV));
    rd(A_STAT, v);  chk("R2 no pending after rev write", v, '0);

    // R3, R11: pending bit and dropped write
    wr(A_LOAD, 32'h100); m_load = 32'h100;
    rd(A_STAT, v);  chk("R3 load pending bit2", v, 32'h04);
    wr(A_LOAD, 32'h200);
    drain();
    rd(A_LOAD, v);  chk("R3 busy write dropped", v, m_load);

    // R7 reload while stopped
    kick(32'h1);
    rd(A_COUNT, v); chk("R7 kick reloads", v, m_load);

    // R11 ctrl readback, bit5 clear so prescaler off
    wr(A_CTRL, 32'h0F);
    rd(A_STAT, v);  chk("R3 ctrl pending bit0", v, 32'h01);
    drain();
    rd(A_CTRL, v);  chk("R11 ctrl readback", v, 32'h0C);

    // R4 start, R8 rate
    wr(A_KEY, 32'hBBBB);
    rd(A_STAT, v);  chk("R3 key pending bit4", v, 32'h10);
    drain(); m_key = 1;
    key(16'h4444);
    check_run("R4 started");
    rate(32, d);    chk("R8 one per slow cycle", d, 32'd32);

    // R7 equal kick ignored, different kick reloads
    rd(A_COUNT, ca);
    kick(32'h1);
    rd(A_COUNT, cb); chk("R7 equal kick ignored", CW'(cb > ca), 32'd1);
    wr(A_KICK, 32'hFFFF_FFFE);
    rd(A_STAT, v);  chk("R3 kick pending bit3", v, 32'h08);
    drain(); m_last_kick = 32'hFFFF_FFFE;
    rd(A_COUNT, cb); chk("R7 new kick reloads", CW'(cb - m_load < 8), 32'd1);

    // R6 broken stop
    key(16'hAAAA); key(16'h1234);
    check_run("R6 wrong second word keeps running");
    // R5 stop
    key(16'hAAAA); key(16'h5555);
    check_run("R5 stopped");
    // R6 broken starts
    key(16'h4444);
    check_run("R6 lone second word");
    key(16'hBBBB); key(16'h0000);
    check_run("R6 wrong second word");
    key(16'hBBBB); key(16'hBBBB); key(16'h4444);
    check_run("R6 repeated first word");
    chk("R6 model still stopped", CW'(m_run), '0);

    // R9 prescaler
    wrw(A_CTRL, 32'h28);
    key(16'hBBBB); key(16'h4444);
    rate(64, d); chk("R9 ratio 2", d, 32'd16);
    wrw(A_CTRL, 32'h2C);
    rate(64, d); chk("R9 ratio 3", d, 32'd8);
    wrw(A_CTRL, 32'h20);
    rate(32, d); chk("R9 ratio 0", d, 32'd32);
    key(16'hAAAA); key(16'h5555);
    wrw(A_CTRL, 32'h00);

    // R10 wrap
    wrw(A_LOAD, 32'hFFFF_FFF0); m_load = 32'hFFFF_FFF0;
    kick(32'h2);
    rd(A_COUNT, v); chk("R7 reload near top", v, m_load);
    pulse_ok = 1'b1;
    key(16'hBBBB); key(16'h4444);
    settle(40);
    check_run("R10 keeps running after wrap");
    key(16'hAAAA); key(16'h5555);
    settle(8);
    rd(A_COUNT, v); chk("R10 wrapped", CW'(v < 32'h100), 32'd1);
    chk("R10 single pulse", CW'(pulses), 32'd1);

    finish_up();
  end
endmodule